// File: doc/BRIEF.md
# Prime-Field Transform Butterfly (modulus 19)

This block is the arithmetic core of one radix-2 step of a number-theoretic transform carried out in the integers modulo the prime 19. Each clock it may accept a data residue `a`, a data residue `b` and a twiddle factor. The twiddle is not given as a value. It is given as its exponent `k` with respect to the primitive root 2. The block returns the pair `a + αb` and `a − αb`, each reduced into 0..18.

The product `αb` is formed in the logarithm domain. A table turns `b` into its exponent, and that exponent is added to the twiddle exponent modulo 18. A second table turns the folded exponent back into a residue. A reserved code stands for the missing logarithm of zero, and whenever either operand carries it the product is forced to zero. The sum and the difference are then taken with plain binary arithmetic. Two separate tables fold them back into the field. The first covers raw sums from 0 to 36, and the second covers signed raw differences from −18 to +18.

Every stage has a register on the common clock, so a new operand set can enter on every cycle. A valid flag travels with the data. Transform sequencing and twiddle generation belong to the surrounding logic.

Top module: `modp_butterfly`

## Requirements
- R1: With valid input, `out_sum` equals (a + α·b) mod 19 and always lies in 0..18.
- R2: With valid input, `out_dif` equals (a − α·b) mod 19. A negative raw difference is mapped to its positive residue, for example −7 gives 12.
- R3: `in_tw_idx` holds an exponent k in 0..17, which encodes α = 2^k mod 19. The code 31 (all ones) encodes α = 0. Codes 18..30 are not to be driven.
- R4: When b = 0 or `in_tw_idx` = 31, both outputs equal a.
- R5: `out_valid` is high exactly three rising edges after the edge that sampled `in_valid` high. The results appear at the outputs together with `out_valid`.
- R6: Operand sets presented on consecutive cycles each produce their own independent result, one per clock.
- R7: While `rst` is high at a rising edge, `out_valid`, `out_sum` and `out_dif` are cleared to 0.
- R8: With a = 7, b = 12 and k = 10 (α = 17), the block gives `out_sum` = 2 and `out_dif` = 12.
- R9: When `out_valid` is low, `out_sum` and `out_dif` keep the value they held on the previous cycle. Operands presented with `in_valid` low have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operand set as valid |
| in_a | input | 5 | Residue a, 0..18 |
| in_b | input | 5 | Residue b, 0..18 |
| in_tw_idx | input | 5 | Twiddle exponent k, 0..17, or 31 for a zero twiddle |
| out_valid | output | 1 | Result valid |
| out_sum | output | 5 | (a + α·b) mod 19 |
| out_dif | output | 5 | (a − α·b) mod 19 |

## Verification
In any one cycle, the zero-operand path of the multiplier and the wraparound corrections of the add and subtract stages may be active in neighbouring pipeline stages. The same holds for an idle slot and a valid result. The stimulus sweeps every combination of a, b and exponent, including the zero twiddle code, one per clock. This places zero products directly beside results that wrap past 19 or below 0, and idle slots with junk operands are inserted at irregular intervals. A behavioural model of the field arithmetic, delayed by a queue, judges both outputs and the valid flag on every cycle. It also confirms that the outputs hold through each idle slot.

// File: rtl/modp_pkg.sv
package modp_pkg;
  // base^e mod p by repeated multiplication (elaboration-time use only)
  function automatic int mod_pow(int base, int e, int p);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = (r * base) % p;
    return r;
  endfunction

  // exponent k with root^k == g (mod p); -1 when g has no logarithm
  function automatic int disc_log(int g, int root, int p);
    for (int k = 0; k < p - 1; k++)
      if (mod_pow(root, k, p) == g) return k;
    return -1;
  endfunction

  // least non-negative residue of a possibly negative value
  function automatic int fold_mod(int v, int p);
    int r;
    r = v % p;
    if (r < 0) r = r + p;
    return r;
  endfunction
endpackage

// File: rtl/modp_log_stage.sv
module modp_log_stage
  import modp_pkg::*;
#(
  parameter int PRIME = 19,
  parameter int ROOT  = 2,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_tw,
  output logic         s1_valid,
  output logic [W-1:0] s1_a,
  output logic [W-1:0] s1_bidx,
  output logic [W-1:0] s1_tw
);
  localparam int          LSZ = 1 << W;
  localparam logic [W-1:0] ZC = '1;

  // logarithm ROM; zero and out-of-field values carry the zero code
  logic [W-1:0] log_rom [LSZ];
  for (genvar g = 0; g < LSZ; g++) begin : g_log
    if (g == 0 || g >= PRIME) begin : g_zero
      assign log_rom[g] = ZC;
    end else begin : g_val
      assign log_rom[g] = W'(disc_log(g, ROOT, PRIME));
    end
  end

  always_ff @(posedge clk) begin
    s1_valid <= rst ? 1'b0 : in_valid;
    s1_a     <= in_a;
    s1_bidx  <= log_rom[in_b];
    s1_tw    <= in_tw;
  end
endmodule

// File: rtl/modp_exp_stage.sv
module modp_exp_stage
  import modp_pkg::*;
#(
  parameter int PRIME = 19,
  parameter int ROOT  = 2,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_a,
  input  logic [W-1:0] s1_bidx,
  input  logic [W-1:0] s1_tw,
  output logic         s2_valid,
  output logic [W-1:0] s2_a,
  output logic [W-1:0] s2_prod
);
  localparam int           LSZ   = 1 << W;
  localparam logic [W-1:0] ZC    = '1;
  localparam logic [W:0]   ORDER = (W+1)'(PRIME - 1);

  // antilog ROM over the group order
  logic [W-1:0] exp_rom [LSZ];
  for (genvar g = 0; g < LSZ; g++) begin : g_exp
    if (g < PRIME - 1) begin : g_val
      assign exp_rom[g] = W'(mod_pow(ROOT, g, PRIME));
    end else begin : g_pad
      assign exp_rom[g] = '0;
    end
  end

  logic [W:0]   idx_sum;
  logic [W:0]   idx_wrap;
  logic         prod_zero;

  always_comb begin
    idx_sum   = {1'b0, s1_bidx} + {1'b0, s1_tw};
    idx_wrap  = (idx_sum >= ORDER) ? idx_sum - ORDER : idx_sum;
    prod_zero = (s1_bidx == ZC) || (s1_tw == ZC);
  end

  always_ff @(posedge clk) begin
    s2_valid <= rst ? 1'b0 : s1_valid;
    s2_a     <= s1_a;
    s2_prod  <= prod_zero ? '0 : exp_rom[idx_wrap[W-1:0]];
  end
endmodule

// File: rtl/modp_addsub_stage.sv
module modp_addsub_stage
  import modp_pkg::*;
#(
  parameter int PRIME = 19,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s2_valid,
  input  logic [W-1:0] s2_a,
  input  logic [W-1:0] s2_prod,
  output logic         out_valid,
  output logic [W-1:0] out_sum,
  output logic [W-1:0] out_dif
);
  localparam int SW  = W + 1;
  localparam int TSZ = 1 << SW;

  // correction ROMs: unsigned raw sum and two's-complement raw difference
  logic [W-1:0] add_rom [TSZ];
  logic [W-1:0] sub_rom [TSZ];
  for (genvar g = 0; g < TSZ; g++) begin : g_fix
    localparam int SV = (g >= TSZ / 2) ? g - TSZ : g;
    assign add_rom[g] = W'(fold_mod(g, PRIME));
    assign sub_rom[g] = W'(fold_mod(SV, PRIME));
  end

  logic [SW-1:0] raw_sum;
  logic [SW-1:0] raw_dif;

  always_comb begin
    raw_sum = {1'b0, s2_a} + {1'b0, s2_prod};
    raw_dif = {1'b0, s2_a} - {1'b0, s2_prod};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_dif   <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_sum <= add_rom[raw_sum];
        out_dif <= sub_rom[raw_dif];
      end
    end
  end
endmodule

// File: rtl/modp_butterfly.sv
module modp_butterfly #(
  parameter  int PRIME = 19,
  parameter  int ROOT  = 2,
  localparam int W     = $clog2(PRIME)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_tw_idx,
  output logic         out_valid,
  output logic [W-1:0] out_sum,
  output logic [W-1:0] out_dif
);
  logic         s1_valid, s2_valid;
  logic [W-1:0] s1_a, s1_bidx, s1_tw;
  logic [W-1:0] s2_a, s2_prod;

  modp_log_stage #(.PRIME(PRIME), .ROOT(ROOT), .W(W)) u_log (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_tw(in_tw_idx), .s1_valid(s1_valid), .s1_a(s1_a),
    .s1_bidx(s1_bidx), .s1_tw(s1_tw)
  );

  modp_exp_stage #(.PRIME(PRIME), .ROOT(ROOT), .W(W)) u_exp (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_a(s1_a),
    .s1_bidx(s1_bidx), .s1_tw(s1_tw), .s2_valid(s2_valid),
    .s2_a(s2_a), .s2_prod(s2_prod)
  );

  modp_addsub_stage #(.PRIME(PRIME), .W(W)) u_fix (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_a(s2_a),
    .s2_prod(s2_prod), .out_valid(out_valid), .out_sum(out_sum),
    .out_dif(out_dif)
  );
endmodule

// File: rtl/modp_butterfly_chk.sv
module modp_butterfly_chk #(
  parameter  int PRIME = 19,
  localparam int W     = $clog2(PRIME)
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] in_tw_idx,
  input logic         out_valid,
  input logic [W-1:0] out_sum,
  input logic [W-1:0] out_dif
);
  localparam logic [W-1:0] ZC = '1;

  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_zero_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid &&
     ($past(in_b, 3) == '0 || $past(in_tw_idx, 3) == ZC))
    |-> (out_sum == $past(in_a, 3) && out_dif == $past(in_a, 3)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_sum) && $stable(out_dif)));

  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum < W'(PRIME) && out_dif < W'(PRIME)));

  assert_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sum == '0 && out_dif == '0));
endmodule

bind modp_butterfly modp_butterfly_chk #(.PRIME(PRIME)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .in_tw_idx(in_tw_idx), .out_valid(out_valid), .out_sum(out_sum),
  .out_dif(out_dif)
);

// File: tb/modp_butterfly_tb_top.sv
module modp_butterfly_tb_top;
  localparam int P  = 19;
  localparam int W  = 5;
  localparam int ZC = 31;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_tw_idx = '0;
  logic         out_valid;
  logic [W-1:0] out_sum, out_dif;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modp_butterfly dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_tw_idx(in_tw_idx), .out_valid(out_valid), .out_sum(out_sum),
    .out_dif(out_dif)
  );

  typedef struct { bit vld; int s; int d; bit zero; bit ex; } exp_t;
  exp_t q[$];
  int last_s = 0, last_d = 0;

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // alpha from exponent code per R3
  function automatic int alpha_of(int k);
    int r;
    if (k == ZC) return 0;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * 2) % P;
    return r;
  endfunction

  // compare outputs (at negedge) with entry driven three negedges earlier
  task automatic compare_front();
    exp_t e;
    e = q.pop_front();
    if (e.vld) begin
      check(out_valid == 1'b1, "R5 R6 valid", int'(out_valid), 1);
      check(int'(out_sum) == e.s, e.ex ? "R8 sum" : (e.zero ? "R4 sum" : "R1 R3 sum"), int'(out_sum), e.s);
      check(int'(out_dif) == e.d, e.ex ? "R8 dif" : (e.zero ? "R4 dif" : "R2 R3 dif"), int'(out_dif), e.d);
      last_s = e.s;
      last_d = e.d;
    end else begin
      check(out_valid == 1'b0, "R5 idle", int'(out_valid), 0);
      check(int'(out_sum) == last_s, "R9 hold sum", int'(out_sum), last_s);
      check(int'(out_dif) == last_d, "R9 hold dif", int'(out_dif), last_d);
    end
  endtask

  task automatic step(bit v, int a, int b, int k, bit ex);
    exp_t e;
    int pr;
    @(negedge clk);
    compare_front();
    in_valid  = v;
    in_a      = W'(a);
    in_b      = W'(b);
    in_tw_idx = W'(k);
    pr = (alpha_of(k) * b) % P;
    e.vld  = v;
    e.s    = (a + pr) % P;
    e.d    = (a - pr + P) % P;
    e.zero = (b == 0) || (k == ZC);
    e.ex   = ex;
    q.push_back(e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    // R7: reset with junk valid inputs present
    in_valid = 1'b1; in_a = 5'd7; in_b = 5'd3; in_tw_idx = 5'd2;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
    check(out_sum == '0, "R7 sum", int'(out_sum), 0);
    check(out_dif == '0, "R7 dif", int'(out_dif), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 3; i++) q.push_back('{vld: 1'b0, s: 0, d: 0, zero: 1'b0, ex: 1'b0});

    // R8 worked example, alpha = 2^10 mod 19 = 17
    step(1'b1, 7, 12, 10, 1'b1);
    step(1'b0, 18, 18, 3, 1'b0);  // R9: junk operands while idle
    // R6: full sweep, one set per clock, with irregular idle slots
    n = 0;
    for (int kk = 0; kk < 19; kk++) begin
      for (int a = 0; a < P; a++) begin
        for (int b = 0; b < P; b++) begin
          n++;
          if (n % 11 == 5) step(1'b0, (a + 5) % P, (b + 9) % P, (kk * 3) % 18, 1'b0);
          step(1'b1, a, b, (kk == 18) ? ZC : kk, 1'b0);
        end
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule